// File: doc/BRIEF.md
# Flash Operation Engine With Status Polling

This block executes write-type operations on a small on-chip byte array and serves reads from it. A command decoder upstream hands it one request at a time: program a byte, erase the whole array, or set the boot-region lock. Program and erase each keep the engine busy for their own parameterised number of clocks. The array changes only when that count runs out.

While the engine is busy, a read does not return array contents. It returns a status byte. Bit 7 of that byte is the inverse of bit 7 of the byte being written, and bit 6 flips on every read. Software can therefore poll either bit to find the end of an operation. With the identification input held high and the engine idle, low addresses return fixed identity codes and the lock state.

The lock bit protects the lowest `BOOT_SIZE` bytes of the array. Erase skips that region, and program requests aimed at it are dropped. Nothing except reset clears the lock.

Top module: `flash_op_engine`

## Requirements
- R1: After reset, `busy` is 0, `rd_data` is 00h, every array byte reads FFh and the lock is clear.
- R2: An accepted program request holds `busy` high for exactly `PROG_CYCLES` clocks. An accepted erase request holds it high for exactly `ERASE_CYCLES` clocks. The request op encoding is 0 = program, 1 = erase, 2 = lock, 3 = no-op.
- R3: A request presented while `busy` is high has no effect on the array, the lock or the busy timing.
- R4: A program stores the bitwise AND of the old byte and the new data, so bits only go from 1 to 0.
- R5: Erase writes FFh to every byte. When the lock is set, bytes at addresses below `BOOT_SIZE` keep their value.
- R6: With the lock set, a program request to an address below `BOOT_SIZE` changes nothing and does not raise `busy`, so the next read returns true data.
- R7: A read while busy returns on bit 7 the inverse of bit 7 of the byte being written. For erase, that byte is FFh.
- R8: Bit 6 of a busy read is 0 on the first read after acceptance and flips on each following busy read. Bits 5..0 of a busy read are 0.
- R9: When idle with `id_mode` high, address 0 reads 1Fh, address 1 reads 0Bh, address 2 reads the lock on bit 0 (1 = locked), and every other address reads 00h.
- R10: A lock request sets the lock at once without raising `busy`, and a later erase does not clear it.
- R11: `rd_data` updates on the clock edge where `rd_en` is high and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_op | input | 2 | Operation: 0 program, 1 erase, 2 lock, 3 none |
| req_addr | input | ADDR_W | Byte address for program |
| req_data | input | 8 | Program data |
| id_mode | input | 1 | Selects identification reads while idle |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Registered read result |
| busy | output | 1 | High while an operation runs |

## Verification
If the countdown is wrong, `busy` falls too early or too late, and the error shows in the busy count of the operation that is running. A corrupted target register shows on bit 7 of the very next poll, and a stuck toggle shows on the second poll. Array damage caused by a dropped lock check or an OR in place of an AND stays hidden until that address is read back. For that reason every program is followed by a read of its address, every erase by checks on both sides of the boundary, and every window in which a stray request arrived by a read of the stray address.

// File: rtl/flash_pkg.sv
package flash_pkg;
    typedef enum logic [1:0] {
        OP_PROG  = 2'd0,
        OP_ERASE = 2'd1,
        OP_LOCK  = 2'd2,
        OP_NOP   = 2'd3
    } flash_op_e;
endpackage

// File: rtl/flash_array.sv
module flash_array #(
    parameter int ADDR_W    = 10,
    parameter int BOOT_SIZE = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [7:0]        prog_data,
    input  logic              erase_en,
    input  logic              lock,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_word
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else if (erase_en) begin
            for (int i = 0; i < DEPTH; i++)
                if (!(lock && (i < BOOT_SIZE))) mem_q[i] <= 8'hFF;
        end else if (prog_en) begin
            mem_q[prog_addr] <= mem_q[prog_addr] & prog_data;
        end
    end

    assign rd_word = mem_q[rd_addr];

    // R6: the sequencer never commits a program into a locked boot byte
    a_r6_no_boot_commit: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en |-> !(lock && ({1'b0, prog_addr} < (ADDR_W+1)'(BOOT_SIZE))));
    // R4: after a program, no bit is set where the data had a 0
    a_r4_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en |=> ((mem_q[$past(prog_addr)] & ~$past(prog_data)) == 8'h00));
    // R5: erase without lock restores the bottom byte
    a_r5_erase_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_en && !lock) |=> (mem_q[0] == 8'hFF));
endmodule

// File: rtl/flash_read_mux.sv
module flash_read_mux #(
    parameter int         ADDR_W    = 10,
    parameter logic [7:0] MFR_CODE  = 8'h1F,
    parameter logic [7:0] DEV_CODE  = 8'h0B
) (
    input  logic              busy,
    input  logic              id_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        word,
    input  logic              tgt7,
    input  logic              tog,
    input  logic              lock,
    output logic [7:0]        byte_o
);
    always_comb begin
        if (busy) begin
            byte_o = {~tgt7, tog, 6'b0};
        end else if (id_mode) begin
            if (addr == ADDR_W'(0))      byte_o = MFR_CODE;
            else if (addr == ADDR_W'(1)) byte_o = DEV_CODE;
            else if (addr == ADDR_W'(2)) byte_o = {7'b0, lock};
            else                         byte_o = 8'h00;
        end else begin
            byte_o = word;
        end
    end
endmodule

// File: rtl/flash_op_seq.sv
module flash_op_seq
    import flash_pkg::*;
#(
    parameter int ADDR_W       = 10,
    parameter int BOOT_SIZE    = 256,
    parameter int PROG_CYCLES  = 8,
    parameter int ERASE_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_data,
    input  logic              rd_en,
    input  logic [7:0]        rd_byte,
    output logic              busy,
    output logic              lock,
    output logic              tgt7,
    output logic              tog,
    output logic              prog_en,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [7:0]        prog_data,
    output logic              erase_en,
    output logic [7:0]        rd_data
);
    localparam int CNT_MAX = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        logic              busy;
        logic              is_erase;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
        logic              lock;
        logic              tog;
        logic [7:0]        rd_data;
    } seq_state_t;

    seq_state_t q, d;
    logic in_boot;

    assign in_boot = ({1'b0, req_addr} < (ADDR_W+1)'(BOOT_SIZE));

    always_comb begin
        d        = q;
        prog_en  = 1'b0;
        erase_en = 1'b0;
        if (rd_en) begin
            d.rd_data = rd_byte;
            if (q.busy) d.tog = ~q.tog;
        end
        if (q.busy) begin
            d.cnt = q.cnt - CNT_W'(1);
            if (q.cnt == CNT_W'(1)) begin
                d.busy = 1'b0;
                if (q.is_erase) erase_en = 1'b1;
                else            prog_en  = 1'b1;
            end
        end else if (req_valid) begin
            case (flash_op_e'(req_op))
                OP_PROG: begin
                    if (!(q.lock && in_boot)) begin
                        d.busy     = 1'b1;
                        d.is_erase = 1'b0;
                        d.cnt      = CNT_W'(PROG_CYCLES);
                        d.addr     = req_addr;
                        d.data     = req_data;
                        d.tog      = 1'b0;
                    end
                end
                OP_ERASE: begin
                    d.busy     = 1'b1;
                    d.is_erase = 1'b1;
                    d.cnt      = CNT_W'(ERASE_CYCLES);
                    d.data     = 8'hFF;
                    d.tog      = 1'b0;
                end
                OP_LOCK: d.lock = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy      = q.busy;
    assign lock      = q.lock;
    assign tgt7      = q.data[7];
    assign tog       = q.tog;
    assign prog_addr = q.addr;
    assign prog_data = q.data;
    assign rd_data   = q.rd_data;

    // R2: a busy engine always has time left on its counter
    a_r2_count_live: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> (q.cnt != '0));
    // R2: program and erase never commit together
    a_r2_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_en, erase_en}));
    // R3: a request during busy leaves the target untouched
    a_r3_target_held: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && req_valid) |=> ($stable(q.addr) && $stable(q.data)));
    // R7: a busy poll returns the inverted target bit 7
    a_r7_poll_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && q.busy) |=> (q.rd_data[7] != $past(q.data[7])));
    // R8: each busy poll flips the toggle and zeroes the low bits
    a_r8_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && q.busy) |=> (q.tog != $past(q.tog)));
    a_r8_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && q.busy) |=> (q.rd_data[5:0] == 6'd0));
    // R10: the lock never clears once set
    a_r10_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        q.lock |=> q.lock);
endmodule

// File: rtl/flash_op_engine.sv
module flash_op_engine #(
    parameter int         ADDR_W       = 10,
    parameter int         BOOT_SIZE    = 256,
    parameter int         PROG_CYCLES  = 8,
    parameter int         ERASE_CYCLES = 20,
    parameter logic [7:0] MFR_CODE     = 8'h1F,
    parameter logic [7:0] DEV_CODE     = 8'h0B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_data,
    input  logic              id_mode,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy
);
    logic              lock_w, tgt7_w, tog_w, prog_en_w, erase_en_w;
    logic [ADDR_W-1:0] prog_addr_w;
    logic [7:0]        prog_data_w, word_w, mux_byte_w;

    flash_op_seq #(
        .ADDR_W(ADDR_W), .BOOT_SIZE(BOOT_SIZE),
        .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .rd_en(rd_en),
        .rd_byte(mux_byte_w), .busy(busy), .lock(lock_w), .tgt7(tgt7_w),
        .tog(tog_w), .prog_en(prog_en_w), .prog_addr(prog_addr_w),
        .prog_data(prog_data_w), .erase_en(erase_en_w), .rd_data(rd_data)
    );

    flash_array #(.ADDR_W(ADDR_W), .BOOT_SIZE(BOOT_SIZE)) u_arr (
        .clk(clk), .rst_n(rst_n), .prog_en(prog_en_w), .prog_addr(prog_addr_w),
        .prog_data(prog_data_w), .erase_en(erase_en_w), .lock(lock_w),
        .rd_addr(rd_addr), .rd_word(word_w)
    );

    flash_read_mux #(.ADDR_W(ADDR_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_mux (
        .busy(busy), .id_mode(id_mode), .addr(rd_addr), .word(word_w),
        .tgt7(tgt7_w), .tog(tog_w), .lock(lock_w), .byte_o(mux_byte_w)
    );
endmodule

// File: tb/flash_op_engine_tb_top.sv
module flash_op_engine_tb_top;
    localparam int AW = 10;
    localparam int DEPTH = 1 << AW;
    localparam int BOOT = 256;
    localparam int PC = 8;
    localparam int EC = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_op = 2'd3;
    logic [AW-1:0] req_addr = '0;
    logic [7:0] req_data = '0;
    logic id_mode = 1'b0;
    logic rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic busy;

    int vecs = 0;
    int bad = 0;
    logic [7:0] model [DEPTH];
    logic locked = 1'b0;
    logic tog_m = 1'b0;

    always #10 clk = ~clk;

    flash_op_engine #(.ADDR_W(AW), .BOOT_SIZE(BOOT), .PROG_CYCLES(PC), .ERASE_CYCLES(EC)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .id_mode(id_mode),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
    );

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_idle(input logic [AW-1:0] a);
        if (id_mode) begin
            if (a == 0) return 8'h1F;
            if (a == 1) return 8'h0B;
            if (a == 2) return {7'b0, locked};
            return 8'h00;
        end
        return model[a];
    endfunction

    task automatic rd(input string r, input logic [AW-1:0] a);
        logic [7:0] e;
        e = exp_idle(a);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        chk(r, rd_data, e);
    endtask

    task automatic send(input logic [1:0] op, input logic [AW-1:0] a, input logic [7:0] dt);
        req_valid = 1'b1; req_op = op; req_addr = a; req_data = dt;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // polls while busy, injects stray requests (R3), counts busy cycles (R2)
    task automatic run_busy(input string r, input int n, input logic t7);
        int cnt = 0;
        logic pend = 1'b0;
        logic [7:0] e = 8'h00;
        logic stray = 1'b0;
        logic [AW-1:0] stray_a = '0;
        tog_m = 1'b0;
        while (busy === 1'b1 && cnt < 1000) begin
            cnt++;
            pend = ($urandom % 2) == 0;
            rd_en = pend; rd_addr = AW'($urandom);
            if (pend) begin e = {~t7, tog_m, 6'b0}; tog_m = ~tog_m; end
            if (($urandom % 4) == 0) begin
                req_valid = 1'b1; req_op = 2'($urandom % 3 == 0 ? 1 : 0);
                if (req_op == 2'd1) req_op = 2'd0;
                req_addr = AW'($urandom % (DEPTH - BOOT) + BOOT); req_data = 8'h00;
                stray = 1'b1; stray_a = req_addr;
            end else req_valid = 1'b0;
            @(negedge clk);
            if (pend) chk("R7/R8 busy status", rd_data, e);
        end
        rd_en = 1'b0; req_valid = 1'b0;
        chk({r, " busy length"}, cnt, n);
        if (stray) begin
            pend = 1'b1;
            rd_en = 1'b1; rd_addr = stray_a;
            @(negedge clk);
            rd_en = 1'b0;
        end
        // model update is done by the caller; stray address is checked after it
        if (stray && stray_a != req_addr_last) chk("R3 stray ignored", rd_data, model[stray_a]);
    endtask

    logic [AW-1:0] req_addr_last = '0;

    task automatic do_prog(input logic [AW-1:0] a, input logic [7:0] dt);
        if (locked && a < BOOT) begin
            send(2'd0, a, dt);
            chk("R6 no busy", busy, 0);
            rd("R6 boot unchanged", a);
        end else begin
            req_addr_last = a;
            send(2'd0, a, dt);
            chk("R2 busy raised", busy, 1);
            model[a] = model[a] & dt;
            run_busy("R2 program", PC, dt[7]);
            rd("R4 and-program", a);
        end
    endtask

    task automatic do_erase();
        req_addr_last = '0;
        send(2'd1, '0, 8'h00);
        chk("R2 busy raised", busy, 1);
        for (int i = 0; i < DEPTH; i++)
            if (!(locked && i < BOOT)) model[i] = 8'hFF;
        run_busy("R2 erase", EC, 1'b1);
        rd("R5 boot edge", AW'(BOOT - 1));
        rd("R5 above boot", AW'(BOOT));
        rd("R5 top", AW'(DEPTH - 1));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        int unsigned seed;
        logic [7:0] hold;
        seed = $urandom(32'd4242);
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 busy after reset", busy, 0);
        chk("R1 rd_data after reset", rd_data, 8'h00);
        rd("R1 erased array", 10'd5);
        rd("R1 erased array", 10'd700);

        do_prog(10'd3, 8'hA5);
        do_prog(10'd3, 8'h0F);
        do_prog(10'd400, 8'h3C);
        do_erase();
        rd("R5 unlocked boot erased", 10'd3);
        do_prog(10'd3, 8'h05);

        id_mode = 1'b1;
        rd("R9 maker code", 10'd0);
        rd("R9 device code", 10'd1);
        rd("R9 unlocked", 10'd2);
        rd("R9 other id", 10'd3);
        send(2'd2, '0, 8'h00);
        locked = 1'b1;
        chk("R10 lock no busy", busy, 0);
        rd("R10 lock visible", 10'd2);
        id_mode = 1'b0;

        do_prog(10'd3, 8'h00);
        do_prog(10'd255, 8'h00);
        do_prog(10'd256, 8'h12);
        do_prog(10'd300, 8'h7E);
        do_erase();
        rd("R5 locked boot kept", 10'd3);
        rd("R5 erased above boot", 10'd300);
        id_mode = 1'b1;
        rd("R10 lock survives erase", 10'd2);
        id_mode = 1'b0;

        for (int k = 0; k < 250; k++) begin
            int pick = $urandom % 20;
            if (pick == 0) do_erase();
            else if (pick < 14) do_prog(AW'($urandom), 8'($urandom));
            else rd("R4 random readback", AW'($urandom));
        end

        rd("R11 read", 10'd300);
        hold = rd_data;
        rd_addr = 10'd3;
        repeat (3) @(negedge clk);
        chk("R11 hold without rd_en", rd_data, hold);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end
endmodule